// File: doc/BRIEF.md
# Masked Multi-Write Register Bank

This block is a bank of eight general-purpose data registers that sits beside a simple accumulator datapath. Each write cycle, one of four sources is chosen: a constant zero, the immediate value carried by the instruction, the ALU result, or data just read from memory. The selected value is then loaded into every register whose bit is set in an 8-bit write mask. The mask is the low byte of the instruction operand, and the controller qualifies it with a single write strobe.

The same operand byte also carries the read address. Its three lowest bits are a binary index, and the addressed register is driven onto the read port without any clock delay, so the datapath can use it in the cycle the index appears. Setting several mask bits at once fills a group of registers in one cycle. Pairing the zero source with a wide mask clears many registers in a single instruction. The data width is a parameter, 8 bits by default.

Top module: `regbank_onehot`

## Requirements
- R1: A synchronous reset, sampled at a rising clock edge, sets all eight registers to zero, and it wins over any write requested in that same cycle.
- R2: With `src_sel` = 2'b00 and the strobe high, every register enabled by the mask is loaded with zero.
- R3: With `src_sel` = 2'b01 and the strobe high, every register enabled by the mask is loaded with `imm_data`.
- R4: With `src_sel` = 2'b10 and the strobe high, every register enabled by the mask is loaded with `alu_data`.
- R5: With `src_sel` = 2'b11 and the strobe high, every register enabled by the mask is loaded with `mem_data`.
- R6: Bit i of `opnd_lo` enables register i. A register whose mask bit is clear keeps its value through a write cycle.
- R7: When several mask bits are set, every enabled register loads the same source value at the same clock edge.
- R8: While `wr_strobe` is low, no register changes, whatever the mask and source inputs are.
- R9: `rd_data` shows the register addressed by `opnd_lo[2:0]` (binary index) in the same cycle the index is applied, and a written value is visible there right after the writing edge.
- R10: A write cycle with an all-zero mask leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_strobe | input | 1 | Write qualifier from the controller |
| src_sel | input | 2 | Write source: 00 zero, 01 immediate, 10 ALU, 11 memory |
| imm_data | input | DATA_W | Immediate/control data source |
| alu_data | input | DATA_W | ALU result source |
| mem_data | input | DATA_W | Memory read data source |
| opnd_lo | input | NUM_REGS | Low operand byte: write mask in all bits, read index in bits [2:0] |
| rd_data | output | DATA_W | Contents of the indexed register |

## Verification
Each register is visible only through the read port, so a bad load enable or a wrong source choice shows up only once that register is indexed. That can be the first read after the faulty edge, or much later if the register is not addressed for a while. For this reason the bench reads back all eight registers after every write vector. A stray write to an unmasked register, a mask bit mapped to the wrong register, or a dropped strobe gate therefore appears at the ports within one cycle. A fault in the read multiplexer shows in the same cycle the index is applied.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [1:0] {
    SRC_ZERO = 2'b00,
    SRC_IMM  = 2'b01,
    SRC_ALU  = 2'b10,
    SRC_MEM  = 2'b11
  } wsrc_e;
endpackage

// File: rtl/regbank_src_mux.sv
module regbank_src_mux
  import regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  wsrc_e              sel,
  input  logic [DATA_W-1:0]  imm,
  input  logic [DATA_W-1:0]  alu,
  input  logic [DATA_W-1:0]  mem,
  output logic [DATA_W-1:0]  src
);
  // Four-way choice of the value to be written into the bank.
  function automatic logic [DATA_W-1:0] pick_source(
    input wsrc_e s,
    input logic [DATA_W-1:0] i_v,
    input logic [DATA_W-1:0] a_v,
    input logic [DATA_W-1:0] m_v
  );
    unique case (s)
      SRC_ZERO: pick_source = '0;
      SRC_IMM:  pick_source = i_v;
      SRC_ALU:  pick_source = a_v;
      default:  pick_source = m_v;
    endcase
  endfunction

  always_comb src = pick_source(sel, imm, alu, mem);
endmodule

// File: rtl/regbank_wr_gate.sv
module regbank_wr_gate #(
  parameter int NUM_REGS = 8
) (
  input  logic                strobe,
  input  logic [NUM_REGS-1:0] mask,
  output logic [NUM_REGS-1:0] load_vec
);
  // The strobe qualifies every mask bit, so bit i becomes the load enable of register i.
  function automatic logic [NUM_REGS-1:0] gate_mask(
    input logic s,
    input logic [NUM_REGS-1:0] m
  );
    gate_mask = m & {NUM_REGS{s}};
  endfunction

  always_comb load_vec = gate_mask(strobe, mask);
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  // Hold mux plus flop; reset takes priority over load.
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/regbank_rd_mux.sv
module regbank_rd_mux #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [IDX_W-1:0]                idx,
  output logic [DATA_W-1:0]               dout
);
  always_comb dout = regs[idx];
endmodule

// File: rtl/regbank_onehot.sv
module regbank_onehot
  import regbank_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_strobe,
  input  logic [1:0]          src_sel,
  input  logic [DATA_W-1:0]   imm_data,
  input  logic [DATA_W-1:0]   alu_data,
  input  logic [DATA_W-1:0]   mem_data,
  input  logic [NUM_REGS-1:0] opnd_lo,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int IDX_W = $clog2(NUM_REGS);

  // Internal events, named so the checker can observe them.
  wsrc_e                          sel_e;
  logic [DATA_W-1:0]              src_value;
  logic [NUM_REGS-1:0]            load_vec;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
  logic [IDX_W-1:0]               rd_idx;

  assign sel_e  = wsrc_e'(src_sel);
  assign rd_idx = opnd_lo[IDX_W-1:0];

  regbank_src_mux #(.DATA_W(DATA_W)) u_src (
    .sel(sel_e), .imm(imm_data), .alu(alu_data), .mem(mem_data), .src(src_value)
  );

  regbank_wr_gate #(.NUM_REGS(NUM_REGS)) u_gate (
    .strobe(wr_strobe), .mask(opnd_lo), .load_vec(load_vec)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
    regbank_cell #(.DATA_W(DATA_W)) u_cell (
      .clk(clk), .rst(rst), .load(load_vec[g]), .d(src_value), .q(reg_q[g])
    );
  end

  regbank_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rd (
    .regs(reg_q), .idx(rd_idx), .dout(rd_data)
  );
endmodule

// File: rtl/regbank_onehot_chk.sv
module regbank_onehot_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            wr_strobe,
  input logic [1:0]                      src_sel,
  input logic [NUM_REGS-1:0]             opnd_lo,
  input logic [DATA_W-1:0]               src_value,
  input logic [NUM_REGS-1:0]             load_vec,
  input logic [NUM_REGS-1:0][DATA_W-1:0] reg_q,
  input logic [DATA_W-1:0]               rd_data
);
  // R1: the edge after a reset cycle leaves the indexed register at zero
  assert_reset_R1: assert property (@(posedge clk) rst |=> (rd_data == '0));

  // R2: the zero source really supplies zero
  assert_zero_src_R2: assert property (@(posedge clk) disable iff (rst)
    (src_sel == 2'b00) |-> (src_value == '0));

  // R8: no load enable without the strobe
  assert_no_load_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_strobe |-> (load_vec == '0));

  // R7: the enables never exceed the mask
  assert_mask_bound_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(load_vec) <= $countones(opnd_lo));

  // R9: the read port matches the indexed register
  assert_read_R9: assert property (@(posedge clk) disable iff (rst)
    rd_data == reg_q[opnd_lo[IDX_W-1:0]]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    // R6: a register without its enable holds
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !load_vec[g] |=> $stable(reg_q[g]));
    // R3: an enabled register takes the selected source
    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
      load_vec[g] |=> (reg_q[g] == $past(src_value)));
  end
endmodule

bind regbank_onehot regbank_onehot_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .src_sel(src_sel), .opnd_lo(opnd_lo),
  .src_value(src_value), .load_vec(load_vec), .reg_q(reg_q), .rd_data(rd_data)
);

// File: tb/regbank_onehot_tb.sv
module regbank_onehot_tb;
  localparam int W  = 8;
  localparam int N  = 8;
  localparam int NV = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_strobe = 1'b0;
  logic [1:0]   src_sel = 2'b00;
  logic [W-1:0] imm_data = '0, alu_data = '0, mem_data = '0;
  logic [N-1:0] opnd_lo = '0;
  logic [W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model [N];

  always #5 clk = ~clk;

  regbank_onehot #(.DATA_W(W), .NUM_REGS(N)) u_dut (
    .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .src_sel(src_sel),
    .imm_data(imm_data), .alu_data(alu_data), .mem_data(mem_data),
    .opnd_lo(opnd_lo), .rd_data(rd_data)
  );

  // Vector: {strobe, sel, mask, imm, alu, mem}
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 2'b01, 8'h01, 8'h3C, 8'h00, 8'h00},
    {1'b1, 2'b10, 8'h02, 8'h00, 8'hA5, 8'h00},
    {1'b1, 2'b11, 8'h80, 8'h00, 8'h00, 8'h7E},
    {1'b1, 2'b01, 8'h0C, 8'h11, 8'h22, 8'h33},
    {1'b0, 2'b01, 8'hFF, 8'hEE, 8'hEE, 8'hEE},
    {1'b1, 2'b00, 8'h01, 8'h44, 8'h55, 8'h66},
    {1'b1, 2'b11, 8'h00, 8'h99, 8'h99, 8'h99},
    {1'b1, 2'b10, 8'hF0, 8'h12, 8'hC3, 8'h34},
    {1'b1, 2'b00, 8'h08, 8'hFF, 8'hFF, 8'hFF},
    {1'b1, 2'b01, 8'h20, 8'h5F, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic string tag_for(input logic s, input logic [1:0] sel,
                                    input logic [7:0] m, input int r);
    if (!s) return "R8";
    if (m == 8'h00) return "R10";
    if (!m[r]) return "R6";
    if ($countones(m) > 1) return "R7";
    case (sel)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic read_all(input string why, input logic s, input logic [1:0] sel,
                          input logic [7:0] m);
    for (int r = 0; r < N; r++) begin
      opnd_lo = N'(r);
      #1;
      check((why.len() != 0) ? why : tag_for(s, sel, m, r), rd_data, model[r]);
    end
  endtask

  initial begin
    for (int r = 0; r < N; r++) model[r] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    read_all("R1", 1'b0, 2'b00, 8'h00);

    for (int v = 0; v < NV; v++) begin
      logic s; logic [1:0] sel; logic [7:0] m; logic [W-1:0] iv, av, mv, src;
      {s, sel, m, iv, av, mv} = VEC[v];
      @(negedge clk);
      wr_strobe = s; src_sel = sel; opnd_lo = m;
      imm_data = iv; alu_data = av; mem_data = mv;
      @(negedge clk);
      wr_strobe = 1'b0;
      case (sel)
        2'b00: src = '0;
        2'b01: src = iv;
        2'b10: src = av;
        default: src = mv;
      endcase
      if (s) for (int r = 0; r < N; r++) if (m[r]) model[r] = src;
      read_all("", s, sel, m);
    end

    // R9: combinational read and visibility right after the writing edge
    @(negedge clk);
    wr_strobe = 1'b1; src_sel = 2'b01; imm_data = 8'h5A; opnd_lo = 8'h20;
    @(posedge clk);
    #1;
    wr_strobe = 1'b0;
    opnd_lo = 8'h05;
    #1;
    check("R9", rd_data, 8'h5A);
    model[5] = 8'h5A;
    opnd_lo = 8'h07;
    #1;
    check("R9", rd_data, model[7]);

    // R1: reset wins over a full-mask write in the same cycle
    @(negedge clk);
    rst = 1'b1; wr_strobe = 1'b1; src_sel = 2'b01; imm_data = 8'hAA; opnd_lo = 8'hFF;
    @(negedge clk);
    rst = 1'b0; wr_strobe = 1'b0;
    for (int r = 0; r < N; r++) model[r] = '0;
    read_all("R1", 1'b0, 2'b00, 8'h00);

    // R7 then R2: fill all with memory data, clear all with the zero source
    @(negedge clk);
    wr_strobe = 1'b1; src_sel = 2'b11; mem_data = 8'h81; opnd_lo = 8'hFF;
    @(negedge clk);
    wr_strobe = 1'b0;
    for (int r = 0; r < N; r++) model[r] = 8'h81;
    read_all("R7", 1'b0, 2'b00, 8'h00);
    @(negedge clk);
    wr_strobe = 1'b1; src_sel = 2'b00; opnd_lo = 8'hFF;
    @(negedge clk);
    wr_strobe = 1'b0;
    for (int r = 0; r < N; r++) model[r] = '0;
    read_all("R2", 1'b0, 2'b00, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule